// File: doc/BRIEF.md
# T1 Facility Data Link Transmit Buffer

This block supplies the outgoing data-link bit for every data-link slot of a T1 transmit formatter. A processor writes a byte into a holding register. At each unit boundary that byte is copied into a shift register and sent one bit per slot strobe, least significant bit first. In extended-superframe operation a unit is eight bits long, which spans sixteen frames. In superframe operation a unit is the six-bit Fs framing pattern, which spans twelve frames, and the two upper bits of the byte are not used. The unit length is fixed when the unit is loaded. No zero insertion is done. If the processor writes nothing new, the same byte is sent again.

A source-select input can route an external alternate bit to the output instead. While that happens the buffer sequence holds its place. When the last bit of a unit goes out, a latched empty flag is set. A write of one to the clear input clears it, and a set in the same cycle wins over the clear. The interrupt output is the flag gated by a mask input.

The sequencer is a two-state machine. In `ST_BOUND` the next strobe loads the holding byte and sends its bit 0, and the machine moves to `ST_SHIFT` (the load transition). In `ST_SHIFT` each strobe sends the next bit. The strobe that sends bit 7 (extended superframe) or bit 5 (superframe) returns the machine to `ST_BOUND` and raises the empty flag (the unit-done transition). Every other strobe stays in `ST_SHIFT`. With no strobe, the machine stays in its current state.

Top module: `fdl_tx_buffer`

## Requirements
- R1: After reset, tx_bit, empty_stat and irq are all 0.
- R2: While src_sel is 1, each slot strobe sets tx_bit to alt_bit, and the buffer sequence neither advances nor sets empty_stat. When src_sel returns to 0, sending resumes at the next unsent bit of the byte.
- R3: With src_sel 0 and sf_mode 0, eight strobes send bits 0 through 7 of the loaded byte, least significant bit first. tx_bit updates in the cycle after the strobe is sampled.
- R4: In extended-superframe mode (sf_mode 0), empty_stat is 0 after seven strobes of a unit and is 1 right after the eighth.
- R5: If the holding register is not rewritten, the next unit sends the same byte again.
- R6: A write during a unit does not change the bits of that unit. The new value is sent from the next unit on.
- R7: In superframe mode (sf_mode 1), a unit is bits 0 through 5 of the byte. Bits 7:6 are ignored, and empty_stat sets right after the sixth strobe.
- R8: The byte 0x1C in superframe mode sends the Fs pattern 0,0,1,1,1,0.
- R9: A one on stat_clr clears empty_stat. If a unit ends in the same cycle, empty_stat stays 1.
- R10: irq is 1 exactly when empty_stat is 1 and irq_mask is 1.
- R11: The unit length is sampled from sf_mode at the load. Changing sf_mode mid-unit does not change that unit's length.
- R12: No zero is inserted, so the byte 0xFF sent twice gives sixteen consecutive ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sf_mode | input | 1 | 1 = superframe (6-bit Fs unit), 0 = extended superframe (8-bit unit) |
| src_sel | input | 1 | 0 = send from buffer, 1 = pass alt_bit |
| alt_bit | input | 1 | Alternate data-link bit |
| slot_stb | input | 1 | One-cycle pulse per data-link or Fs slot |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | 8 | Holding register write value |
| stat_clr | input | 1 | Write-one clear of empty_stat |
| irq_mask | input | 1 | Interrupt enable for empty_stat |
| tx_bit | output | 1 | Outgoing slot bit |
| empty_stat | output | 1 | Latched buffer-empty flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest case to reach from the ports is a unit that is interrupted part-way. This happens when the alternate source takes over mid-byte, or when the framing mode flips after a load, and the sequencer must still resume and end at the right bit. The stimulus sends a few bits of a byte, then switches src_sel or sf_mode for a few strobes, then switches back. The scoreboard queue holds exactly the remaining bits, and empty_stat is sampled one strobe before the end of the unit and again right after it. The clear-versus-set collision is produced by pulsing stat_clr together with the final strobe of a unit.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
    typedef enum logic {
        ST_BOUND = 1'b0,
        ST_SHIFT = 1'b1
    } seq_state_t;
endpackage

// File: rtl/fdl_hold_reg.sv
module fdl_hold_reg #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= RST_VAL;
        else if (wr_en) q <= wr_data;
    end

    // R6: the holding value changes only on a processor write
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/fdl_evt_latch.sv
module fdl_evt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    a_r4_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
    a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);
endmodule

// File: rtl/fdl_tx_seq.sv
module fdl_tx_seq
    import fdl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SF_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              sf_mode,
    input  logic [DATA_W-1:0] hold_val,
    output logic              cur_bit,
    output logic              unit_done
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] ESF_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] SF_LAST  = CNT_W'(SF_W - 1);

    seq_state_t        state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_q;
    logic              at_last;

    assign at_last = (cnt_q == last_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOUND;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOUND: if (adv)            state_d = ST_SHIFT;
            ST_SHIFT: if (adv && at_last) state_d = ST_BOUND;
            default:                      state_d = ST_BOUND;
        endcase
    end

    // outputs
    always_comb begin
        cur_bit   = 1'b0;
        unit_done = 1'b0;
        unique case (state_q)
            ST_BOUND: cur_bit = hold_val[0];
            ST_SHIFT: begin
                cur_bit   = shreg_q[0];
                unit_done = adv && at_last;
            end
            default: cur_bit = 1'b0;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            last_q  <= ESF_LAST;
        end else if (adv) begin
            if (state_q == ST_BOUND) begin
                shreg_q <= hold_val >> 1;
                cnt_q   <= CNT_W'(1);
                last_q  <= sf_mode ? SF_LAST : ESF_LAST;
            end else begin
                shreg_q <= shreg_q >> 1;
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    a_r2_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(state_q) && $stable(cnt_q) && $stable(shreg_q)));
    a_r11_len_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |=> $stable(last_q));
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (cnt_q != '0 && cnt_q <= last_q));
endmodule

// File: rtl/fdl_tx_buffer.sv
module fdl_tx_buffer #(
    parameter int DATA_W = 8,
    parameter int SF_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sf_mode,
    input  logic              src_sel,
    input  logic              alt_bit,
    input  logic              slot_stb,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stat_clr,
    input  logic              irq_mask,
    output logic              tx_bit,
    output logic              empty_stat,
    output logic              irq
);
    logic [DATA_W-1:0] hold_val;
    logic              adv;
    logic              cur_bit;
    logic              unit_done;

    assign adv = slot_stb && !src_sel;

    fdl_hold_reg #(.W(DATA_W), .RST_VAL('0)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .q(hold_val)
    );

    fdl_tx_seq #(.DATA_W(DATA_W), .SF_W(SF_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .adv(adv), .sf_mode(sf_mode),
        .hold_val(hold_val), .cur_bit(cur_bit), .unit_done(unit_done)
    );

    fdl_evt_latch u_empty (
        .clk(clk), .rst_n(rst_n), .set(unit_done), .clr(stat_clr), .q(empty_stat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        tx_bit <= 1'b0;
        else if (slot_stb) tx_bit <= src_sel ? alt_bit : cur_bit;
    end

    assign irq = empty_stat && irq_mask;

    a_r2_alt_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && src_sel) |=> (tx_bit == $past(alt_bit)));
    a_r2_alt_no_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel && !empty_stat) |=> !empty_stat);
    a_r3_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_stb |=> $stable(tx_bit));
endmodule

// File: tb/sim_fdl_tx_buffer.sv
`timescale 1ns/1ps
module sim_fdl_tx_buffer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sf_mode = 1'b0, src_sel = 1'b0, alt_bit = 1'b0, slot_stb = 1'b0;
    logic wr_en = 1'b0, stat_clr = 1'b0, irq_mask = 1'b0;
    logic [7:0] wr_data = '0;
    logic tx_bit, empty_stat, irq;

    int total = 0;
    int bad   = 0;
    int exp_q[$];   // entry = req*2 + expected bit

    always #2 clk = ~clk;

    fdl_tx_buffer u0 (
        .clk(clk), .rst_n(rst_n), .sf_mode(sf_mode), .src_sel(src_sel),
        .alt_bit(alt_bit), .slot_stb(slot_stb), .wr_en(wr_en), .wr_data(wr_data),
        .stat_clr(stat_clr), .irq_mask(irq_mask),
        .tx_bit(tx_bit), .empty_stat(empty_stat), .irq(irq)
    );

    task automatic chk(input int req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_bits(input logic [7:0] v, input int first, input int n, input int req);
        for (int i = first; i < first + n; i++) exp_q.push_back(req * 2 + int'(v[i]));
    endtask

    task automatic stb(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) slot_stb = 1'b1;
            @(negedge clk) slot_stb = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic stb_with_clr();
        @(negedge clk) begin slot_stb = 1'b1; stat_clr = 1'b1; end
        @(negedge clk) begin slot_stb = 1'b0; stat_clr = 1'b0; end
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk) begin wr_en = 1'b1; wr_data = v; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk) stat_clr = 1'b1;
        @(negedge clk) stat_clr = 1'b0;
    endtask

    // monitor: compare each strobed bit against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            if (slot_stb === 1'b1) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R3: actual=%b expected=none (unexpected strobe)", tx_bit);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(e / 2, tx_bit, logic'(e % 2));
                end
            end
        end
    end

    initial begin
        #150000;
        total++; bad++;
        $display("FAIL R1: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(1, tx_bit, 1'b0);
        chk(1, empty_stat, 1'b0);
        chk(1, irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, empty_stat, 1'b0);

        // R3 / R4 / R10 / R9
        wr(8'hA5);
        push_bits(8'hA5, 0, 8, 3);
        stb(7);
        chk(4, empty_stat, 1'b0);
        stb(1);
        chk(4, empty_stat, 1'b1);
        chk(10, irq, 1'b0);
        @(negedge clk) irq_mask = 1'b1;
        @(negedge clk);
        chk(10, irq, 1'b1);
        clr();
        chk(9, empty_stat, 1'b0);
        chk(10, irq, 1'b0);

        // R5: no rewrite, same byte again
        push_bits(8'hA5, 0, 8, 5);
        stb(8);
        chk(5, empty_stat, 1'b1);

        // R6: write mid-byte
        push_bits(8'hA5, 0, 3, 6);
        stb(3);
        wr(8'h3C);
        push_bits(8'hA5, 3, 5, 6);
        stb(5);
        push_bits(8'h3C, 0, 8, 6);
        stb(8);

        // R12 / R9: all ones, clear collides with unit end
        wr(8'hFF);
        clr();
        push_bits(8'hFF, 0, 8, 12);
        stb(7);
        chk(9, empty_stat, 1'b0);
        stb_with_clr();
        chk(9, empty_stat, 1'b1);
        push_bits(8'hFF, 0, 8, 12);
        stb(8);

        // R2: alternate source mid-byte
        clr();
        wr(8'h96);
        push_bits(8'h96, 0, 3, 2);
        stb(3);
        @(negedge clk) src_sel = 1'b1;
        for (int i = 0; i < 4; i++) begin
            logic b;
            b = (i == 0 || i == 3);
            @(negedge clk) alt_bit = b;
            exp_q.push_back(2 * 2 + int'(b));
            stb(1);
        end
        chk(2, empty_stat, 1'b0);
        @(negedge clk) src_sel = 1'b0;
        push_bits(8'h96, 3, 5, 2);
        stb(4);
        chk(2, empty_stat, 1'b0);
        stb(1);
        chk(2, empty_stat, 1'b1);

        // R8 / R7: superframe pattern, upper bits ignored
        clr();
        @(negedge clk) sf_mode = 1'b1;
        wr(8'hDC);
        push_bits(8'h1C, 0, 6, 8);
        stb(5);
        chk(7, empty_stat, 1'b0);
        stb(1);
        chk(7, empty_stat, 1'b1);
        clr();
        wr(8'hE5);
        push_bits(8'hE5, 0, 6, 7);
        stb(5);
        chk(7, empty_stat, 1'b0);
        stb(1);
        chk(7, empty_stat, 1'b1);

        // R11: mode change mid-unit keeps length
        clr();
        wr(8'h2B);
        push_bits(8'h2B, 0, 6, 11);
        stb(2);
        @(negedge clk) sf_mode = 1'b0;
        stb(3);
        chk(11, empty_stat, 1'b0);
        stb(1);
        chk(11, empty_stat, 1'b1);
        clr();
        push_bits(8'h2B, 0, 8, 11);
        stb(7);
        chk(11, empty_stat, 1'b0);
        stb(1);
        chk(11, empty_stat, 1'b1);

        repeat (4) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R3: actual=%0d pending expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule